// File: doc/BRIEF.md
# Baseline Command Packet Receiver

This block sits behind a bit slicer that has already turned the track waveform into a stream of logical bits. It rebuilds three-byte baseline command packets from that stream. Packets are framed by a floating run of one bits with no separate clock. After a run of at least ten ones, the first zero starts a packet. The block then collects three bytes, each sent most significant bit first, checks the zero separator before the second and third bytes, checks the one bit that closes the packet, and checks that the third byte equals the XOR of the first two.

Only a packet that passes every check is delivered. Delivery is a one-cycle pulse that carries the address byte and the instruction byte. Anything malformed is dropped without a trace, and the block goes back to hunting for the next valid run of ones. The one bit that closes a packet, or that spoils a separator slot, counts as the first one of the next run.

The bit input is a valid/ready stream. `in_ready` is always high, because the block takes one bit on every cycle in which `in_valid` is high. The sender may leave any number of idle cycles between bits. The output side has no back-pressure: the downstream logic must capture `out_addr` and `out_instr` while `out_valid` is high. Both values also stay put until the next accepted packet.

Top module: `pkt_rx`

## Requirements
- R1: After reset, `out_valid` is 0, `out_addr` and `out_instr` are 0x00, and `in_ready` is 1.
- R2: A zero bit starts a packet only if at least 10 consecutive one bits came before it. A zero after 9 ones does not start a packet, and the bits that follow it do not produce an output.
- R3: A run of ones of any length, such as 40, is accepted as a preamble. The run counter saturates and does not wrap.
- R4: The first byte after the start bit appears on `out_addr` and the second on `out_instr`, each assembled with the first received bit as bit 7.
- R5: A one bit in the separator slot before the second or third byte drops the packet.
- R6: After the third byte, a one bit completes the packet. A zero in that slot means an extended packet, which is not supported, and the packet is dropped.
- R7: A packet whose third byte differs from the XOR of its first two bytes is dropped.
- R8: After any dropped or completed packet, the next valid preamble starts a new packet. A one bit that ends a packet or spoils a separator counts as the first preamble one, so 9 further ones are enough.
- R9: For an accepted packet, `out_valid` is high for exactly one clock cycle: the cycle after the clock edge that takes the end bit.
- R10: `out_addr` and `out_instr` change only together with an `out_valid` pulse. Dropped packets leave them unchanged.
- R11: Idle cycles between bits (`in_valid` low) have no effect on framing or on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A recovered bit is present on `in_bit` |
| in_bit | input | 1 | Value of the recovered bit |
| in_ready | output | 1 | Always 1; every offered bit is taken |
| out_valid | output | 1 | One-cycle pulse for an accepted packet |
| out_addr | output | 8 | Address byte of the last accepted packet |
| out_instr | output | 8 | Instruction byte of the last accepted packet |

## Verification
A wrong run count or a wrong frame state shows up at the end-bit edge of the packet that is under way. A good packet then gives no pulse, or a bad one gives a pulse, in the cycle after the end bit is taken. A byte shifter that drifts by one position corrupts `out_addr` or `out_instr` in that same pulse, and it usually fails the XOR check as well, so the pulse goes missing. A fault in the hold logic shows up in the cycles right after a dropped packet, as output bytes that change while `out_valid` is low.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_SEP  = 2'd2,
    ST_END  = 2'd3
  } frame_st_t;
endpackage

// File: rtl/pkt_pre_cnt.sv
// Counts consecutive ones while hunting; saturates at MIN_ONES.
module pkt_pre_cnt #(
  parameter int MIN_ONES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic stb,
  input  logic bit_i,
  input  logic seed,
  output logic qualified
);
  localparam int CNT_W = $clog2(MIN_ONES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_ONES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (seed) begin
      cnt_q <= bit_i ? CNT_W'(1) : '0;
    end else if (stb && hunt) begin
      if (!bit_i)               cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign qualified = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pkt_shift.sv
// MSB-first byte assembler with a bit position counter.
module pkt_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_i,
  output logic              last,
  output logic [BYTE_W-1:0] next_byte
);
  localparam int POS_W = $clog2(BYTE_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q;
  logic [POS_W-1:0]  pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      pos_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
    end else if (shift) begin
      sr_q  <= next_byte;
      pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
    end
  end

  assign last      = (pos_q == POS_LAST);
  assign next_byte = {sr_q[BYTE_W-2:0], bit_i};
endmodule

// File: rtl/pkt_xor_chk.sv
// Passes when the XOR of all received bytes is zero,
// i.e. the last byte equals the XOR of the ones before it.
module pkt_xor_chk #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_i,
  output logic                             ok
);
  logic [NUM_BYTES:0][BYTE_W-1:0] acc;

  assign acc[0] = '0;
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_acc
    assign acc[g+1] = acc[g] ^ bytes_i[g];
  end

  assign ok = (acc[NUM_BYTES] == '0);
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int MIN_ONES  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_addr,
  output logic [BYTE_W-1:0] out_instr
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES - 1);

  frame_st_t state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_q;
  logic [BYTE_W-1:0] addr_q, instr_q, next_byte;
  logic valid_q;

  logic take, hunt, qual, start, shift_en, last, byte_done;
  logic sep_ok, sep_bad, end_take, accept, seed, clear_sh, chk_ok;

  assign in_ready = 1'b1;
  assign take     = in_valid;
  assign hunt     = (state_q == ST_HUNT);
  assign start    = take && hunt && !in_bit && qual;
  assign shift_en = take && (state_q == ST_DATA);
  assign byte_done = shift_en && last;
  assign sep_ok   = take && (state_q == ST_SEP) && !in_bit;
  assign sep_bad  = take && (state_q == ST_SEP) && in_bit;
  assign end_take = take && (state_q == ST_END);
  assign accept   = end_take && in_bit && chk_ok;
  assign seed     = sep_bad || end_take;
  assign clear_sh = start || sep_ok;

  pkt_pre_cnt #(.MIN_ONES(MIN_ONES)) u_pre (
    .clk(clk), .rst_n(rst_n), .hunt(hunt), .stb(take), .bit_i(in_bit),
    .seed(seed), .qualified(qual)
  );

  pkt_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear_sh), .shift(shift_en),
    .bit_i(in_bit), .last(last), .next_byte(next_byte)
  );

  pkt_xor_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
    .bytes_i(bytes_q), .ok(chk_ok)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT: if (start) state_d = ST_DATA;
      ST_DATA: if (byte_done) state_d = (idx_q == IDX_LAST) ? ST_END : ST_SEP;
      ST_SEP:  if (take) state_d = in_bit ? ST_HUNT : ST_DATA;
      ST_END:  if (take) state_d = ST_HUNT;
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      bytes_q <= '0;
    end else begin
      state_q <= state_d;
      if (start)  idx_q <= '0;
      if (sep_ok) idx_q <= idx_q + IDX_W'(1);
      if (byte_done) bytes_q[idx_q] <= next_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      instr_q <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        addr_q  <= bytes_q[0];
        instr_q <= bytes_q[1];
      end
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_instr = instr_q;
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_bit,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_addr,
  input logic [BYTE_W-1:0] out_instr
);
  // Bits taken since reset or since the previous accepted packet, saturating.
  logic [5:0] nbits_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          nbits_q <= '0;
    else if (out_valid)  nbits_q <= in_valid ? 6'd1 : 6'd0;
    else if (in_valid && nbits_q != 6'd63) nbits_q <= nbits_q + 6'd1;
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_end_bit_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_bit));

  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_addr) && $stable(out_instr)));

  // 9 preamble ones after a shared end bit + start + 3 bytes + 2 separators + end
  assert_min_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nbits_q >= 6'd37));
endmodule

bind pkt_rx pkt_rx_chk #(.BYTE_W(BYTE_W)) u_rx_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
  .out_valid(out_valid), .out_addr(out_addr), .out_instr(out_instr)
);

// File: tb/tb_pkt_rx.sv
module tb_pkt_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid;
  logic [7:0] out_addr, out_instr;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_ok = 16'h0000;
  logic prev_v = 1'b0;

  always #5 clk = ~clk;

  pkt_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_instr(out_instr)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        chk(!prev_v, "R9 pulse width", {31'd0, prev_v}, 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected packet", {16'd0, out_addr, out_instr}, 32'd0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({out_addr, out_instr} == e, "R4 bytes", {16'd0, out_addr, out_instr}, {16'd0, e});
        end
      end
      prev_v = out_valid;
    end
  end

  task automatic send_bit(input bit b, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int k = 7; k >= 0; k--) send_bit(v[k], gap);
  endtask

  // bad_sep: 0 none, 1 first separator, 2 second separator
  task automatic send_pkt(input int npre, input bit lead0, input logic [7:0] a,
                          input logic [7:0] i, input logic [7:0] c, input int bad_sep,
                          input bit endb, input int gap, input bit expect_ok,
                          input string req);
    if (lead0) send_bit(1'b0, gap);
    for (int k = 0; k < npre; k++) send_bit(1'b1, gap);
    send_bit(1'b0, gap);
    send_byte(a, gap);
    send_bit(bad_sep == 1, gap);
    send_byte(i, gap);
    send_bit(bad_sep == 2, gap);
    send_byte(c, gap);
    if (expect_ok) begin
      exp_q.push_back({a, i});
      last_ok = {a, i};
    end
    send_bit(endb, 0);
    // R9: pulse visible in the cycle right after the end-bit edge
    chk(out_valid == expect_ok, req, {31'd0, out_valid}, {31'd0, expect_ok});
    @(negedge clk);
    @(negedge clk);
    chk({out_addr, out_instr} == last_ok, "R10 hold", {16'd0, out_addr, out_instr}, {16'd0, last_ok});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 valid", {31'd0, out_valid}, 32'd0);
    chk({out_addr, out_instr} == 16'h0, "R1 bytes", {16'd0, out_addr, out_instr}, 32'd0);
    chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send_pkt(14, 1, 8'h03, 8'h74, 8'h03 ^ 8'h74, 0, 1, 0, 1, "R4 basic packet");
    send_pkt(10, 1, 8'h25, 8'h6A, 8'h25 ^ 8'h6A, 0, 1, 0, 1, "R2 ten ones accepted");
    send_pkt(9,  1, 8'h11, 8'h22, 8'h33, 0, 1, 0, 0, "R2 nine ones rejected");
    send_pkt(40, 1, 8'h5A, 8'h41, 8'h5A ^ 8'h41, 0, 1, 0, 1, "R3 long preamble");
    send_pkt(14, 1, 8'h07, 8'h63, 8'h07 ^ 8'h63, 1, 1, 0, 0, "R5 bad first separator");
    send_pkt(14, 1, 8'h07, 8'h63, 8'h07 ^ 8'h63, 2, 1, 0, 0, "R5 bad second separator");
    send_pkt(14, 1, 8'h44, 8'h55, 8'h44 ^ 8'h55, 0, 1, 0, 1, "R8 recovery after drop");
    send_pkt(14, 1, 8'h12, 8'h34, 8'h12 ^ 8'h34, 0, 0, 0, 0, "R6 zero end bit dropped");
    send_pkt(14, 1, 8'h12, 8'h34, 8'h12 ^ 8'h34 ^ 8'h01, 0, 1, 0, 0, "R7 bad check byte");
    send_pkt(14, 0, 8'h66, 8'h77, 8'h66 ^ 8'h77, 0, 1, 0, 1, "R8 packet after drop");
    // end bit of the previous packet counts as first preamble one
    send_pkt(9,  0, 8'h0F, 8'h70, 8'h0F ^ 8'h70, 0, 1, 0, 1, "R8 end bit shares preamble");
    send_pkt(8,  0, 8'h0F, 8'h70, 8'h0F ^ 8'h70, 0, 1, 0, 0, "R8 eight plus end bit rejected");
    send_pkt(12, 1, 8'h3C, 8'h5B, 8'h3C ^ 8'h5B, 0, 1, 3, 1, "R11 idle gaps");
    send_pkt(14, 1, 8'hFF, 8'h00, 8'hFF, 0, 1, 0, 1, "R4 all-ones address");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 missing pulses", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule